// File: doc/BRIEF.md
# Word Replica Store with Shared Overflow Sets

This block keeps spare copies of individual memory words that were found to be unreliable. Each copy is one word wide and sits in a set-associative table. The set is picked from the low bits of the word address, and the remaining address bits form the tag.

A home set can fill up. When that happens, the block does not refuse the word. It claims one set from a small pool of overflow sets that all home sets share, and records the claim with a per-set overflow flag and a pointer. Later lookups that miss in the home set follow that pointer. An overflow set claimed by one home set is never handed to another one.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. The block takes one request at a time. `req_ready` is high only while the block is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. The response is then presented with `resp_valid` and held unchanged until the consumer raises `resp_ready`. The block returns to idle on the cycle after that handshake.

Top module: `replica_store`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` is 0, and a lookup of any address returns a miss.
- R2: The set index is `req_addr[IDX_W-1:0]` and the tag is the rest of the address bits. Addresses with the same index but different tags are kept as separate entries.
- R3: An insert or lookup that ends in the home set answers one cycle after it is accepted. This covers a home-set hit, a store into a free home way, and a lookup miss while the set's overflow flag is clear. An insert answers with `resp_hit`=0 and `resp_data`=0.
- R4: Inserting an address that is already stored replaces its data and takes up no further way.
- R5: An insert of a new address into a full home set whose overflow flag is clear claims the lowest-numbered unclaimed overflow set. It sets the flag and the pointer, stores the word there, and answers in one cycle without error.
- R6: A lookup that misses in the home set while the overflow flag is set searches the pointed-to overflow set and answers two cycles after acceptance. An insert into a full home set with the flag set also takes two cycles.
- R7: An insert answers `resp_err`=1 and stores nothing in two cases: the set's overflow set is full, or the home set is full with its flag clear and no overflow set is left unclaimed. A lookup never reports an error.
- R8: Once an overflow set is claimed, it stays with its home set. The number of home sets with the flag set always equals the number of claimed overflow sets.
- R9: While a response is pending, `req_ready` is 0. `resp_hit`, `resp_err` and `resp_data` stay stable while `resp_valid` is 1 and `resp_ready` is 0.
- R10: A lookup miss returns `resp_hit`=0 and `resp_data`=0. A hit returns the last data inserted for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 = lookup, 1 = insert |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Replica data for an insert |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | Lookup found the address |
| resp_err | output | 1 | Insert could not be placed |
| resp_data | output | DATA_W | Data of a lookup hit, else 0 |

## Verification
The checker watches the following on every cycle:
- response stability and `req_ready` under back-pressure;
- the one-or-two-cycle answer latency;
- the absence of errors on lookups;
- zero data on misses;
- that claims only grow by at most one per cycle and stay paired with the overflow flags.

Whether the right way, the right overflow set and the right data were used can only be seen through the bench's scenarios. Those scenarios compare each answer against a reference model. They fill sets into overflow, overwrite stored words, fill an overflow set to its error, and use up the whole overflow pool.

// File: rtl/replica_pkg.sv
`timescale 1ns/1ps
package replica_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOME = 2'd1,
    ST_OVF  = 2'd2,
    ST_RESP = 2'd3
  } rs_state_e;

  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_INSERT = 1'b1
  } rs_op_e;
endpackage

// File: rtl/rs_first_one.sv
`timescale 1ns/1ps
// Lowest-index set bit finder.
module rs_first_one #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] pos
);
  always_comb begin
    found = |bits;
    pos   = '0;
    // Walk downwards so the lowest set bit is the last one written.
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/rs_set_probe.sv
`timescale 1ns/1ps
// Compares a key against every way of one set.
// Reports a hit way and the lowest free way.
module rs_set_probe #(
  parameter int WAYS  = 6,
  parameter int TAG_W = 11,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);
  logic [WAYS-1:0] match;
  logic [WAYS-1:0] empty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = valid[w] && (tags[w] == key);
    assign empty[w] = !valid[w];
  end

  rs_first_one #(.N(WAYS), .IW(WAY_W)) u_hit (
    .bits (match),
    .found(hit),
    .pos  (hit_way)
  );

  rs_first_one #(.N(WAYS), .IW(WAY_W)) u_free (
    .bits (empty),
    .found(has_free),
    .pos  (free_way)
  );
endmodule

// File: rtl/replica_store.sv
`timescale 1ns/1ps
module replica_store
  import replica_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  parameter int HOME_SETS = 32,
  parameter int WAYS      = 6,
  parameter int OVF_SETS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_data
);
  localparam int IDX_W = $clog2(HOME_SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int PTR_W = (OVF_SETS > 1) ? $clog2(OVF_SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Request captured at acceptance
  rs_state_e         st, st_n;
  rs_op_e            q_op;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;

  assign q_idx = q_addr[IDX_W-1:0];
  assign q_tag = q_addr[ADDR_W-1:IDX_W];

  // Home table
  logic [WAYS-1:0]              home_v   [HOME_SETS];
  logic [WAYS-1:0][TAG_W-1:0]   home_tag [HOME_SETS];
  logic [WAYS-1:0][DATA_W-1:0]  home_dat [HOME_SETS];
  logic [HOME_SETS-1:0]         home_ofb;
  logic [PTR_W-1:0]             home_ptr [HOME_SETS];

  // Shared overflow pool
  logic [WAYS-1:0]              ovf_v    [OVF_SETS];
  logic [WAYS-1:0][TAG_W-1:0]   ovf_tag  [OVF_SETS];
  logic [WAYS-1:0][DATA_W-1:0]  ovf_dat  [OVF_SETS];
  logic [OVF_SETS-1:0]          ovf_taken;

  // Probes of the home set and its linked overflow set
  logic             h_hit, h_free, o_hit, o_free;
  logic [WAY_W-1:0] h_hway, h_fway, o_hway, o_fway;
  logic [PTR_W-1:0] cur_ptr;

  assign cur_ptr = home_ptr[q_idx];

  rs_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_home_probe (
    .valid   (home_v[q_idx]),
    .tags    (home_tag[q_idx]),
    .key     (q_tag),
    .hit     (h_hit),
    .hit_way (h_hway),
    .has_free(h_free),
    .free_way(h_fway)
  );

  rs_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_ovf_probe (
    .valid   (ovf_v[cur_ptr]),
    .tags    (ovf_tag[cur_ptr]),
    .key     (q_tag),
    .hit     (o_hit),
    .hit_way (o_hway),
    .has_free(o_free),
    .free_way(o_fway)
  );

  // Claim encoder: lowest unclaimed overflow set
  logic             alloc_ok;
  logic [PTR_W-1:0] alloc_idx;

  rs_first_one #(.N(OVF_SETS), .IW(PTR_W)) u_alloc (
    .bits (~ovf_taken),
    .found(alloc_ok),
    .pos  (alloc_idx)
  );

  // Decision logic
  logic              hw_en, ow_en, claim;
  logic [WAY_W-1:0]  hw_way, ow_way;
  logic [PTR_W-1:0]  ow_set;
  logic              r_load, r_hit, r_err;
  logic [DATA_W-1:0] r_data;

  always_comb begin
    st_n   = st;
    hw_en  = 1'b0;
    hw_way = h_fway;
    ow_en  = 1'b0;
    ow_way = o_fway;
    ow_set = cur_ptr;
    claim  = 1'b0;
    r_load = 1'b0;
    r_hit  = 1'b0;
    r_err  = 1'b0;
    r_data = '0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) st_n = ST_HOME;
      end
      ST_HOME: begin
        if (q_op == OP_LOOKUP) begin
          if (h_hit) begin
            r_load = 1'b1;
            r_hit  = 1'b1;
            r_data = home_dat[q_idx][h_hway];
          end else if (home_ofb[q_idx]) begin
            st_n = ST_OVF;
          end else begin
            r_load = 1'b1;
          end
        end else begin
          if (h_hit) begin
            hw_en  = 1'b1;
            hw_way = h_hway;
            r_load = 1'b1;
          end else if (h_free) begin
            hw_en  = 1'b1;
            r_load = 1'b1;
          end else if (home_ofb[q_idx]) begin
            st_n = ST_OVF;
          end else if (alloc_ok) begin
            claim  = 1'b1;
            ow_en  = 1'b1;
            ow_set = alloc_idx;
            ow_way = '0;
            r_load = 1'b1;
          end else begin
            r_load = 1'b1;
            r_err  = 1'b1;
          end
        end
      end
      ST_OVF: begin
        r_load = 1'b1;
        if (q_op == OP_LOOKUP) begin
          if (o_hit) begin
            r_hit  = 1'b1;
            r_data = ovf_dat[cur_ptr][o_hway];
          end
        end else if (o_hit) begin
          ow_en  = 1'b1;
          ow_way = o_hway;
        end else if (o_free) begin
          ow_en = 1'b1;
        end else begin
          r_err = 1'b1;
        end
      end
      ST_RESP: begin
        if (resp_ready) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (r_load) st_n = ST_RESP;
  end

  // Control state, valid bits, claims and response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      q_op      <= OP_LOOKUP;
      q_addr    <= '0;
      q_data    <= '0;
      home_ofb  <= '0;
      ovf_taken <= '0;
      resp_hit  <= 1'b0;
      resp_err  <= 1'b0;
      resp_data <= '0;
      for (int s = 0; s < HOME_SETS; s++) begin
        home_v[s]   <= '0;
        home_ptr[s] <= '0;
      end
      for (int s = 0; s < OVF_SETS; s++) begin
        ovf_v[s] <= '0;
      end
    end else begin
      st <= st_n;
      if (st == ST_IDLE && req_valid) begin
        q_op   <= rs_op_e'(req_op);
        q_addr <= req_addr;
        q_data <= req_data;
      end
      if (hw_en) home_v[q_idx][hw_way] <= 1'b1;
      if (ow_en) ovf_v[ow_set][ow_way] <= 1'b1;
      if (claim) begin
        ovf_taken[alloc_idx] <= 1'b1;
        home_ofb[q_idx]      <= 1'b1;
        home_ptr[q_idx]      <= alloc_idx;
      end
      if (r_load) begin
        resp_hit  <= r_hit;
        resp_err  <= r_err;
        resp_data <= r_data;
      end
    end
  end

  // Tag and data payload, written without reset
  always_ff @(posedge clk) begin
    if (hw_en) begin
      home_tag[q_idx][hw_way] <= q_tag;
      home_dat[q_idx][hw_way] <= q_data;
    end
    if (ow_en) begin
      ovf_tag[ow_set][ow_way] <= q_tag;
      ovf_dat[ow_set][ow_way] <= q_data;
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign resp_valid = (st == ST_RESP);
endmodule

// File: rtl/replica_store_chk.sv
`timescale 1ns/1ps
module replica_store_chk #(
  parameter int DATA_W    = 64,
  parameter int HOME_SETS = 32,
  parameter int OVF_SETS  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_op,
  input logic                 resp_valid,
  input logic                 resp_ready,
  input logic                 resp_hit,
  input logic                 resp_err,
  input logic [DATA_W-1:0]    resp_data,
  input logic [HOME_SETS-1:0] ofb_vec,
  input logic [OVF_SETS-1:0]  taken_vec
);
  logic       busy;
  logic       op_q;
  logic [2:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op_q <= 1'b0;
      lat  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        busy <= 1'b1;
        op_q <= req_op;
        lat  <= '0;
      end else if (busy && !resp_valid && lat != 3'd7) begin
        lat <= lat + 3'd1;
      end
      if (resp_valid && resp_ready) busy <= 1'b0;
    end
  end

  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit)
      && $stable(resp_err) && $stable(resp_data)));

  p_busy_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  p_accept_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> (lat == 3'd1 || lat == 3'd2));

  p_lookup_noerr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !op_q) |-> !resp_err);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_data == '0));

  p_claim_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_vec & $past(taken_vec)) == $past(taken_vec));

  p_ofb_pairs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ofb_vec) == $countones(taken_vec));

  p_claim_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(taken_vec) <= $countones($past(taken_vec)) + 1);
endmodule

bind replica_store replica_store_chk #(
  .DATA_W   (DATA_W),
  .HOME_SETS(HOME_SETS),
  .OVF_SETS (OVF_SETS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .resp_valid(resp_valid),
  .resp_ready(resp_ready),
  .resp_hit  (resp_hit),
  .resp_err  (resp_err),
  .resp_data (resp_data),
  .ofb_vec   (home_ofb),
  .taken_vec (ovf_taken)
);

// File: tb/replica_store_test.sv
`timescale 1ns/1ps
module replica_store_test;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int NH = 32;
  localparam int NW = 6;
  localparam int NO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          resp_valid;
  logic          resp_ready = 1'b0;
  logic          resp_hit;
  logic          resp_err;
  logic [DW-1:0] resp_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  replica_store uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_hit(resp_hit), .resp_err(resp_err), .resp_data(resp_data)
  );

  // Reference model built from the requirements
  logic [DW-1:0] m_dat [int];
  bit            m_ovf [int];
  int            h_cnt [NH];
  int            o_cnt [NO];
  bit            m_ofb [NH];
  int            m_ptr [NH];
  int            n_claim = 0;
  int            n_exhaust = 0;

  function automatic void predict(input bit op, input logic [AW-1:0] a,
      input logic [DW-1:0] d, output bit eh, output bit ee,
      output logic [DW-1:0] ed, output int el);
    int idx;
    int key;
    idx = int'(a[4:0]);
    key = int'(a);
    eh = 0; ee = 0; ed = '0; el = 1;
    if (!op) begin
      if (m_dat.exists(key)) begin
        eh = 1; ed = m_dat[key]; el = m_ovf[key] ? 2 : 1;
      end else begin
        el = m_ofb[idx] ? 2 : 1;
      end
    end else if (m_dat.exists(key)) begin
      m_dat[key] = d; el = m_ovf[key] ? 2 : 1;
    end else if (h_cnt[idx] < NW) begin
      h_cnt[idx]++; m_dat[key] = d; m_ovf[key] = 0;
    end else if (m_ofb[idx]) begin
      el = 2;
      if (o_cnt[m_ptr[idx]] < NW) begin
        o_cnt[m_ptr[idx]]++; m_dat[key] = d; m_ovf[key] = 1;
      end else ee = 1;
    end else if (n_claim < NO) begin
      m_ofb[idx] = 1; m_ptr[idx] = n_claim; o_cnt[n_claim] = 1;
      n_claim++; m_dat[key] = d; m_ovf[key] = 1;
    end else begin
      ee = 1; n_exhaust++;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // One transaction. hold = cycles of back-pressure on the response.
  task automatic run_op(input bit op, input logic [AW-1:0] a,
      input logic [DW-1:0] d, input int hold, input string req,
      output bit hit, output bit err, output logic [DW-1:0] rd, output int lat);
    bit eh, ee;
    logic [DW-1:0] ed;
    int el;
    predict(op, a, d, eh, ee, ed, el);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 8) begin
      @(posedge clk); #1;
      lat++;
    end
    hit = resp_hit; err = resp_err; rd = resp_data;
    check(hit == eh && err == ee && rd == ed && lat == el, req,
      $sformatf("op=%0d addr=%h got hit=%0d err=%0d data=%h lat=%0d exp hit=%0d err=%0d data=%h lat=%0d",
        op, a, hit, err, rd, lat, eh, ee, ed, el));
    if (hold > 0) begin
      bit steady;
      steady = 1;
      for (int k = 0; k < hold; k++) begin
        @(posedge clk); #1;
        if (!resp_valid || req_ready || resp_data != rd || resp_hit != hit || resp_err != err)
          steady = 0;
      end
      check(steady, "R9", $sformatf("held response moved: valid=%0d ready=%0d data=%h exp data=%h",
        resp_valid, req_ready, resp_data, rd));
    end
    resp_ready = 1'b1;
    @(posedge clk); #1;
    resp_ready = 1'b0;
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return {11'(tag), 5'(idx)};
  endfunction

  initial begin
    bit h, e;
    logic [DW-1:0] rd;
    int lat;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: idle after reset, everything misses
    check(req_ready == 1'b1 && resp_valid == 1'b0, "R1",
      $sformatf("ready=%0d valid=%0d exp 1/0", req_ready, resp_valid));
    run_op(0, mk(5, 3), '0, 0, "R1", h, e, rd, lat);
    run_op(0, mk(0, 0), '0, 1, "R10", h, e, rd, lat);

    // R2, R3: same index 3, distinct tags, five entries
    for (int t = 1; t <= 5; t++) run_op(1, mk(t, 3), 64'hA000 + t, 0, "R3", h, e, rd, lat);
    for (int t = 1; t <= 5; t++) run_op(0, mk(t, 3), '0, 0, "R2", h, e, rd, lat);
    // R4: overwrite, then the sixth distinct tag must still fit at home
    run_op(1, mk(2, 3), 64'hBEEF, 0, "R4", h, e, rd, lat);
    run_op(1, mk(6, 3), 64'hA006, 0, "R4", h, e, rd, lat);
    run_op(0, mk(6, 3), '0, 0, "R4", h, e, rd, lat);
    check(h && lat == 1, "R4", $sformatf("sixth tag hit=%0d lat=%0d exp 1/1", h, lat));
    run_op(0, mk(2, 3), '0, 2, "R10", h, e, rd, lat);
    check(rd == 64'hBEEF, "R10", $sformatf("data=%h exp BEEF", rd));

    // R5: seventh tag claims an overflow set in one cycle
    run_op(1, mk(7, 3), 64'hC007, 0, "R5", h, e, rd, lat);
    check(!e && lat == 1, "R5", $sformatf("claim err=%0d lat=%0d exp 0/1", e, lat));
    // R6: lookup follows the pointer in two cycles; a miss too
    run_op(0, mk(7, 3), '0, 0, "R6", h, e, rd, lat);
    check(h && lat == 2 && rd == 64'hC007, "R6", $sformatf("hit=%0d lat=%0d data=%h", h, lat, rd));
    run_op(0, mk(99, 3), '0, 0, "R6", h, e, rd, lat);
    check(!h && lat == 2, "R6", $sformatf("miss hit=%0d lat=%0d exp 0/2", h, lat));

    // R7: fill the overflow set, the next insert fails and is not stored
    for (int t = 8; t <= 12; t++) run_op(1, mk(t, 3), 64'hD000 + t, 0, "R6", h, e, rd, lat);
    run_op(1, mk(13, 3), 64'hDEAD, 1, "R7", h, e, rd, lat);
    check(e == 1'b1, "R7", $sformatf("full overflow err=%0d exp 1", e));
    run_op(0, mk(13, 3), '0, 0, "R7", h, e, rd, lat);
    check(!h && !e, "R7", $sformatf("rejected word hit=%0d err=%0d exp 0/0", h, e));

    // R8: another home set takes its own overflow set; earlier data intact
    for (int t = 1; t <= 13; t++) run_op(1, mk(t, 7), 64'hE000 + t, 0, "R8", h, e, rd, lat);
    for (int t = 7; t <= 12; t++) run_op(0, mk(t, 3), '0, 0, "R8", h, e, rd, lat);

    // Random mix with back-pressure
    for (int n = 0; n < 600; n++) begin
      int t, ix;
      t  = $urandom_range(0, 14);
      ix = $urandom_range(8, 19);
      run_op(1'($urandom_range(0, 1)), mk(t, ix), {$urandom, $urandom},
        $urandom_range(0, 2), "R2", h, e, rd, lat);
    end

    // R7: use up the overflow pool across all home sets
    for (int ix = 0; ix < NH; ix++)
      for (int t = 200; t < 207; t++) run_op(1, mk(t, ix), 64'hF0 + t, 0, "R7", h, e, rd, lat);
    check(n_exhaust > 0 && n_claim == NO, "R7",
      $sformatf("exhaust events=%0d claims=%0d exp >0/%0d", n_exhaust, n_claim, NO));
    for (int ix = 0; ix < NH; ix++) run_op(0, mk(206, ix), '0, 0, "R10", h, e, rd, lat);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule